// File: doc/BRIEF.md
# Three-Level Translation Table Walker

The block turns a virtual address into a physical address by reading translation descriptors from memory, one table level at a time. Pages and tables are both 4 KiB and every descriptor is 64 bits wide, so each table has 512 entries and each level consumes nine virtual address bits. The low twelve bits of the virtual address go through to the result unchanged. The number of levels follows from the virtual address width parameter. The default of 39 bits gives three levels, and the walk starts at level 1 from the table named by the root base input.

A client presents a virtual address with a valid/ready handshake. While the walker is busy it issues one descriptor read at a time on a memory port that has its own request and response handshakes. At each level the read address is the current table base plus eight times that level's index. A descriptor either points onward to the next table or, at the last level, to the page. A malformed descriptor ends the walk early with a fault that reports its level. Either outcome is signalled by a one-cycle done pulse, and a new request can be taken in that same cycle.

Top module: `pt_walker`

## Requirements
- R1: On a successful walk, `pa[11:0]` equals bits [11:0] of the accepted virtual address.
- R2: The table index at level 1 is VA[38:30], at level 2 it is VA[29:21] and at level 3 it is VA[20:12]. The descriptor read address is the table base plus index times 8, so its three low bits are zero.
- R3: The first read of a walk uses the root base (bits [11:0] treated as zero) as the table base. With the default 39-bit width the walk starts at level 1. A 40-bit width adds a level 0 walked first, and a 38-bit width narrows the top index to eight bits.
- R4: Descriptor bit 0 means valid, bit 1 means it points to a table or page, and bits [47:12] give the next table or page base. All other bits are ignored. A successful walk makes exactly one read per level, and `pa` equals the last descriptor's bits [47:12] followed by the page offset.
- R5: A descriptor with bit 0 clear or bit 1 clear ends the walk at once. No further read is made, `fault` is 1, `fault_level` holds the level as a binary number (1, 2 or 3 by default), and `pa` is zero.
- R6: At most one read is outstanding. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready`, and no new read is issued before the response arrives.
- R7: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high, and the first read follows on the next cycle.
- R8: `done` is a one-cycle pulse. During the pulse, `fault`, `fault_level` and `pa` give the outcome of the walk.
- R9: After reset, `req_ready` is 1 and both `done` and `mem_req_valid` are 0.
- R10: In the cycle `done` is high the walker is idle, so a request waiting on `req_valid` is taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| root_base | input | PA_W | Physical base of the top-level table |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | PA_W | Descriptor byte address |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor contents |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a bad descriptor |
| fault_level | output | 2 | Level at which the fault occurred |
| pa | output | PA_W | Translated physical address |

## Verification
Two events can fall in the same cycle: the completion of one walk and the acceptance of the next request. The bench provokes this by raising `req_valid` with a second address while the first walk is still running. It then checks that `req_ready` is high during the `done` pulse and that a read follows one cycle later. It judges the second walk by its read addresses and result, all computed arithmetically in the bench. The memory model also stalls requests and varies response latency, so a completion can coincide with a stalled or a delayed memory handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int OFS_W   = 12;
   localparam int IDX_W   = 9;
   localparam int DESC_W  = 64;
   localparam int MAX_LVL = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_st_e;

   typedef logic [1:0] lvl_t;

   function automatic int levels_for(input int va_w);
      return (va_w - OFS_W + IDX_W - 1) / IDX_W;
   endfunction
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
   parameter int VA_W = 39
) (
   input  logic [VA_W-1:0]              va,
   input  ptw_pkg::lvl_t                lvl,
   output logic [ptw_pkg::IDX_W-1:0]    idx
);
   import ptw_pkg::*;

   logic [IDX_W-1:0] idx_by_lvl [MAX_LVL];

   for (genvar l = 0; l < MAX_LVL; l++) begin : g_lvl
      localparam int LO = OFS_W + IDX_W * (MAX_LVL - 1 - l);
      if (LO >= VA_W) begin : g_absent
         assign idx_by_lvl[l] = '0;
      end else if (LO + IDX_W <= VA_W) begin : g_full
         assign idx_by_lvl[l] = va[LO +: IDX_W];
      end else begin : g_narrow
         localparam int NW = VA_W - LO;
         assign idx_by_lvl[l] = {{(IDX_W-NW){1'b0}}, va[VA_W-1:LO]};
      end
   end

   assign idx = idx_by_lvl[lvl];
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec #(
   parameter int PA_W = 48
) (
   input  logic [ptw_pkg::DESC_W-1:0] desc,
   output logic                       desc_ok,
   output logic [PA_W-1:0]            next_base
);
   import ptw_pkg::*;

   assign desc_ok   = desc[0] & desc[1];
   assign next_base = {desc[PA_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int VA_W = 39,
   parameter int PA_W = 48
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [VA_W-1:0]            req_va,
   output logic                       req_ready,
   input  logic [PA_W-1:0]            root_base,
   output logic                       mem_req_valid,
   output logic [PA_W-1:0]            mem_req_addr,
   input  logic                       mem_req_ready,
   input  logic                       mem_rsp_valid,
   input  logic [ptw_pkg::DESC_W-1:0] mem_rsp_data,
   output logic                       done,
   output logic                       fault,
   output logic [1:0]                 fault_level,
   output logic [PA_W-1:0]            pa
);
   import ptw_pkg::*;

   localparam int   NUM_LVL   = levels_for(VA_W);
   localparam int   START_LVL = MAX_LVL - NUM_LVL;
   localparam lvl_t LAST_LVL  = lvl_t'(MAX_LVL - 1);

   if (VA_W < OFS_W + IDX_W || VA_W > OFS_W + IDX_W * MAX_LVL) begin : g_bad_va
      $error("pt_walker: VA_W out of supported range");
   end
   if (PA_W <= OFS_W || PA_W > DESC_W - OFS_W) begin : g_bad_pa
      $error("pt_walker: PA_W out of supported range");
   end

   walk_st_e         st_q;
   lvl_t             lvl_q;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  base_q;
   logic             done_q;
   logic             fault_q;
   lvl_t             flvl_q;
   logic [PA_W-1:0]  pa_q;

   logic [IDX_W-1:0] cur_idx;
   logic             desc_ok;
   logic [PA_W-1:0]  next_base;

   ptw_index_sel #(.VA_W(VA_W)) u_idx (
      .va  (va_q),
      .lvl (lvl_q),
      .idx (cur_idx)
   );

   ptw_desc_dec #(.PA_W(PA_W)) u_dec (
      .desc      (mem_rsp_data),
      .desc_ok   (desc_ok),
      .next_base (next_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         lvl_q   <= '0;
         va_q    <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         flvl_q  <= '0;
         pa_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  base_q <= {root_base[PA_W-1:OFS_W], {OFS_W{1'b0}}};
                  lvl_q  <= lvl_t'(START_LVL);
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!desc_ok) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     flvl_q  <= lvl_q;
                     pa_q    <= '0;
                     st_q    <= ST_IDLE;
                  end else if (lvl_q == LAST_LVL) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b0;
                     flvl_q  <= '0;
                     pa_q    <= {next_base[PA_W-1:OFS_W], va_q[OFS_W-1:0]};
                     st_q    <= ST_IDLE;
                  end else begin
                     base_q  <= next_base;
                     lvl_q   <= lvl_q + lvl_t'(1);
                     st_q    <= ST_ISSUE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_ISSUE);
   assign mem_req_addr  = base_q + PA_W'({cur_idx, 3'b000});
   assign done          = done_q;
   assign fault         = fault_q;
   assign fault_level   = flvl_q;
   assign pa            = pa_q;
endmodule

// File: rtl/ptw_walk_chk.sv
module ptw_walk_chk #(
   parameter int VA_W = 39,
   parameter int PA_W = 48
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_req_ready,
   input logic            mem_rsp_valid,
   input logic            done,
   input logic            fault
);
   localparam int NL = ptw_pkg::levels_for(VA_W);

   logic [2:0] rd_cnt_q;
   logic       outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt_q <= '0;
         outst_q  <= 1'b0;
      end else begin
         if (req_valid && req_ready)             rd_cnt_q <= '0;
         else if (mem_req_valid && mem_req_ready) rd_cnt_q <= rd_cnt_q + 3'd1;
         if (mem_req_valid && mem_req_ready)      outst_q <= 1'b1;
         else if (mem_rsp_valid)                  outst_q <= 1'b0;
      end
   end

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !outst_q);

   assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_read_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> rd_cnt_q == 3'(NL));

   assert_fault_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> rd_cnt_q >= 3'd1 && rd_cnt_q <= 3'(NL));

   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && mem_req_valid);

   assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready && !mem_req_valid);
endmodule

bind pt_walker ptw_walk_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_walk_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .mem_rsp_valid (mem_rsp_valid),
   .done          (done),
   .fault         (fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
   localparam int VA_W = 39;
   localparam int PA_W = 48;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [VA_W-1:0] req_va = '0;
   logic            req_ready;
   logic [PA_W-1:0] root_base = '0;
   logic            mem_req_valid;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_req_ready = 1'b0;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            done;
   logic            fault;
   logic [1:0]      fault_level;
   logic [PA_W-1:0] pa;

   always #5 clk = ~clk;

   pt_walker #(.VA_W(VA_W), .PA_W(PA_W)) u0 (.*);

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expectations for the walk in flight
   bit              ex_mode = 0;
   bit              flt_en = 0;
   logic [PA_W-1:0] flt_addr = '0;
   logic [1:0]      flt_lo = 2'b00;
   logic [PA_W-1:0] exp_addr [3];
   int              exp_n = 0;
   int              rd_cnt = 0;
   bit              exp_fault = 0;
   logic [1:0]      exp_flvl = '0;
   logic [PA_W-1:0] exp_pa = '0;

   function automatic logic [63:0] desc_fn(input logic [PA_W-1:0] a);
      logic [35:0] nxt;
      logic [1:0]  lo;
      if (ex_mode) begin
         if (a == 48'h8_0001_0020) return 64'h0000_0008_0002_0003;
         if (a == 48'h8_0002_08D0) return 64'h0000_0008_0003_7003;
         if (a == 48'h8_0003_72B0) return 64'h0000_0008_0004_0003;
      end
      nxt = a[38:3] ^ 36'h5_A3C1_E7B9;
      lo  = 2'b11;
      if (flt_en && a == flt_addr) lo = flt_lo;
      return {16'hC0DE, nxt, 10'h2A5, lo};
   endfunction

   task automatic prep(input logic [VA_W-1:0] va, input int f_lvl, input logic [1:0] f_lo);
      logic [PA_W-1:0] base;
      logic [63:0]     d;
      logic [8:0]      idx;
      base      = {root_base[PA_W-1:12], 12'h000};
      flt_en    = (f_lvl != 0);
      flt_lo    = f_lo;
      exp_fault = 0;
      exp_flvl  = '0;
      exp_pa    = '0;
      exp_n     = 3;
      rd_cnt    = 0;
      for (int lvl = 1; lvl <= 3; lvl++) begin
         idx = 9'((va >> (12 + 9 * (3 - lvl))) & 39'h1FF);
         exp_addr[lvl-1] = base + {36'd0, idx, 3'b000};
         if (lvl == f_lvl) flt_addr = exp_addr[lvl-1];
         d = desc_fn(exp_addr[lvl-1]);
         if (!(d[0] && d[1])) begin
            exp_fault = 1;
            exp_flvl  = 2'(lvl);
            exp_n     = lvl;
            break;
         end
         base = {d[47:12], 12'h000};
      end
      if (!exp_fault) exp_pa = {base[47:12], va[11:0]};
   endtask

   task automatic issue(input logic [VA_W-1:0] va);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_va    = va;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_walk(input string tag);
      while (!done) @(negedge clk);
      chk(fault == exp_fault, {tag, " R5 fault flag"}, 64'(fault), 64'(exp_fault));
      chk(pa == exp_pa, {tag, " R4 R1 physical address"}, 64'(pa), 64'(exp_pa));
      chk(pa[11:0] == (exp_fault ? 12'h000 : exp_pa[11:0]), {tag, " R1 offset"}, 64'(pa[11:0]), 64'(exp_pa[11:0]));
      if (exp_fault)
         chk(fault_level == exp_flvl, {tag, " R5 fault level"}, 64'(fault_level), 64'(exp_flvl));
      chk(rd_cnt == exp_n, {tag, " R4 R5 read count"}, 64'(rd_cnt), 64'(exp_n));
   endtask

   task automatic run_walk(input logic [VA_W-1:0] va, input int f_lvl, input logic [1:0] f_lo, input string tag);
      prep(va, f_lvl, f_lo);
      issue(va);
      finish_walk(tag);
      @(negedge clk);
      chk(!done, {tag, " R8 done pulse width"}, 64'(done), 64'd0);
   endtask

   // Memory model: stalls some requests, varies latency, checks each address.
   int  cyc = 0;
   bit  pend = 0;
   int  lat = 0;
   logic [PA_W-1:0] paddr = '0;

   always @(negedge clk) begin
      cyc++;
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
         mem_req_ready = 1'b0;
      end else if (pend) begin
         if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = desc_fn(paddr);
            pend = 0;
         end else begin
            lat--;
         end
      end else if (rst_n && mem_req_valid && (cyc % 3) != 1) begin
         mem_req_ready = 1'b1;
         pend  = 1;
         lat   = cyc % 2;
         paddr = mem_req_addr;
         if (rd_cnt < exp_n)
            chk(mem_req_addr == exp_addr[rd_cnt], "R2 R3 descriptor read address",
                64'(mem_req_addr), 64'(exp_addr[rd_cnt]));
         else
            chk(1'b0, "R5 R4 read beyond expected count", 64'(rd_cnt), 64'(exp_n));
         rd_cnt++;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [8:0] pick [5];
      logic [VA_W-1:0] va;
      pick[0] = 9'h000; pick[1] = 9'h001; pick[2] = 9'h155; pick[3] = 9'h100; pick[4] = 9'h1FF;

      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R9 reset req_ready", 64'(req_ready), 64'd1);
      chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
      chk(mem_req_valid == 1'b0, "R9 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && !mem_req_valid, "R9 idle after reset", 64'(req_ready), 64'd1);

      // Worked example, VA 0x123456000
      ex_mode   = 1;
      root_base = 48'h8_0001_0ABC;
      run_walk(39'h01_2345_6000, 0, 2'b00, "worked example R2 R3");
      chk(exp_addr[2] == 48'h8_0003_72B0, "R2 level 3 address in example", 64'(exp_addr[2]), 64'h8_0003_72B0);
      ex_mode = 0;

      // Index and offset sweep over several roots
      for (int r = 0; r < 3; r++) begin
         root_base = 48'h0000_4000_0000 + 48'(r) * 48'h1_2345_6789;
         for (int a = 0; a < 5; a++) begin
            va = {pick[a], pick[(a + 2) % 5], pick[(a + 4) % 5], 12'(a * 12'h333 + r)};
            run_walk(va, 0, 2'b00, "sweep R1 R2 R4");
         end
      end

      // Fault at every level with every bad low-bit pattern
      root_base = 48'h0123_4567_8000;
      for (int l = 1; l <= 3; l++) begin
         for (int c = 0; c < 3; c++) begin
            va = {pick[l], pick[c + 1], pick[4 - l], 12'hFED};
            run_walk(va, l, 2'(c), "fault R5");
         end
      end

      // Done and next acceptance in the same cycle
      va = {9'h0AA, 9'h155, 9'h0F0, 12'h123};
      prep(va, 0, 2'b00);
      issue(va);
      req_valid = 1'b1;
      req_va    = {9'h1FF, 9'h000, 9'h1FE, 12'hABC};
      finish_walk("first of pair R10");
      chk(req_ready == 1'b1, "R10 ready during done", 64'(req_ready), 64'd1);
      prep({9'h1FF, 9'h000, 9'h1FE, 12'hABC}, 0, 2'b00);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && mem_req_valid, "R10 R7 accepted at done edge", 64'({req_ready, mem_req_valid}), 64'b01);
      finish_walk("second of pair R10");
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule